// File: doc/BRIEF.md
# Cascadable Interrupt Priority Encoder

This block takes a bank of active-high interrupt request lines and reports the binary number of the most urgent one that is raised, with the highest-numbered line always winning. A pending flag tells the processor that some request is waiting. A chain output is raised when the block is enabled and sees no request, so a further encoder with lower urgency can be switched on behind it.

The basic building piece is a four-line stage with a 2-bit index. The top module chains two such stages into an eight-line encoder with a 3-bit index. The stage that holds the upper lines feeds its chain output into the enable of the lower stage, so the lower stage can only report when the upper one is idle. The block is purely combinational and every signal is active-high.

Top module: `irq_prio_cascade`

## Requirements
- R1: With the enable high and several request lines raised, the index output `irq_idx` is the plain binary number of the highest-numbered raised line (line k is bit k of `irq_req`).
- R2: With the enable low, `irq_idx`, `irq_pending` and `irq_chain_out` are all 0 whatever the request lines hold.
- R3: `irq_pending` is 1 exactly when the enable is high and at least one request line is raised.
- R4: `irq_chain_out` is 1 exactly when the enable is high and no request line is raised.
- R5: With the enable high and no request raised, `irq_idx` is 0, so only `irq_pending` tells idle apart from a request on line 0.
- R6: Any raised line among 4..7 (the upper stage) takes priority over every line among 0..3: `irq_idx[2]` is then 1 and the lower lines have no effect on the index.
- R7: With exactly one line raised, index bit 0 is the OR of lines 1, 3, 5, 7, bit 1 the OR of lines 2, 3, 6, 7 and bit 2 the OR of lines 4..7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| irq_en | input | 1 | Enable for the whole encoder; low forces all outputs to 0 |
| irq_req | input | 8 | Request lines, bit k is line k, higher k is more urgent |
| irq_idx | output | 3 | Binary number of the winning request line |
| irq_pending | output | 1 | High when a request is being reported |
| irq_chain_out | output | 1 | High when enabled with no request, to enable a lower-urgency encoder |

## Verification
A wrong winner in the priority chain of either stage, or a broken hand-off from the upper stage's chain output to the lower stage's enable, shows at the ports in the same evaluation as the request pattern that exposes it, since there is no storage and no latency. Every one of the 256 request patterns is applied with the enable both high and low and compared against a highest-set-bit reference, so any faulty line, bit or gating term shows as a wrong index, pending flag or chain output on the very pattern that touches it.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Default number of request lines handled by one stage.
  localparam int unsigned STAGE_LINES_DEF = 4;

  // Status pair produced by every stage and by the merged cascade.
  typedef struct packed {
    logic pending;
    logic chain;
  } prio_flags_t;

endpackage

// File: rtl/irq_prio_stage.sv
module irq_prio_stage #(
  parameter int unsigned LINES = irq_prio_pkg::STAGE_LINES_DEF,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic                       en,
  input  logic [LINES-1:0]           req,
  output logic [IDX_W-1:0]           idx,
  output irq_prio_pkg::prio_flags_t  flags
);

  // above[i] is high when any line at index i or higher is raised.
  logic [LINES:0]              above;
  logic [LINES-1:0]            win;
  logic [IDX_W-1:0][LINES-1:0] contrib;
  logic                        any_req;

  assign above[LINES] = 1'b0;

  for (genvar i = 0; i < LINES; i++) begin : g_chain
    assign above[i] = above[i+1] | req[i];
    // A line wins only if nothing above it is raised.
    assign win[i]   = req[i] & ~above[i+1];
  end

  // Encode the one-hot winner into binary: bit b collects lines whose number has bit b set.
  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    for (genvar i = 0; i < LINES; i++) begin : g_line
      if (((i >> b) % 2) == 1) begin : g_set
        assign contrib[b][i] = win[i];
      end else begin : g_clr
        assign contrib[b][i] = 1'b0;
      end
    end
    assign idx[b] = en & (|contrib[b]);
  end

  assign any_req       = above[0];
  assign flags.pending = en & any_req;
  assign flags.chain   = en & ~any_req;

endmodule

// File: rtl/irq_prio_merge.sv
module irq_prio_merge #(
  parameter int unsigned SIDX_W = 2,
  localparam int unsigned IDX_W = SIDX_W + 1
) (
  input  logic [SIDX_W-1:0]          hi_idx,
  input  irq_prio_pkg::prio_flags_t  hi_flags,
  input  logic [SIDX_W-1:0]          lo_idx,
  input  irq_prio_pkg::prio_flags_t  lo_flags,
  output logic [IDX_W-1:0]           idx,
  output irq_prio_pkg::prio_flags_t  flags
);

  // The lower stage is only enabled when the upper one is idle, so at most
  // one of the two index buses is non-zero and an OR combines them.
  assign idx           = {hi_flags.pending, hi_idx | lo_idx};
  assign flags.pending = hi_flags.pending | lo_flags.pending;
  assign flags.chain   = lo_flags.chain;

endmodule

// File: rtl/irq_prio_cascade.sv
module irq_prio_cascade #(
  parameter int unsigned STAGE_LINES = irq_prio_pkg::STAGE_LINES_DEF,
  localparam int unsigned LINES  = 2 * STAGE_LINES,
  localparam int unsigned SIDX_W = $clog2(STAGE_LINES),
  localparam int unsigned IDX_W  = SIDX_W + 1
) (
  input  logic             irq_en,
  input  logic [LINES-1:0] irq_req,
  output logic [IDX_W-1:0] irq_idx,
  output logic             irq_pending,
  output logic             irq_chain_out
);

  logic [SIDX_W-1:0]         hi_idx, lo_idx;
  irq_prio_pkg::prio_flags_t hi_flags, lo_flags, out_flags;

  irq_prio_stage #(.LINES(STAGE_LINES)) u_hi (
    .en    (irq_en),
    .req   (irq_req[LINES-1:STAGE_LINES]),
    .idx   (hi_idx),
    .flags (hi_flags)
  );

  // Upper stage's chain output enables the lower stage.
  irq_prio_stage #(.LINES(STAGE_LINES)) u_lo (
    .en    (hi_flags.chain),
    .req   (irq_req[STAGE_LINES-1:0]),
    .idx   (lo_idx),
    .flags (lo_flags)
  );

  irq_prio_merge #(.SIDX_W(SIDX_W)) u_merge (
    .hi_idx   (hi_idx),
    .hi_flags (hi_flags),
    .lo_idx   (lo_idx),
    .lo_flags (lo_flags),
    .idx      (irq_idx),
    .flags    (out_flags)
  );

  assign irq_pending   = out_flags.pending;
  assign irq_chain_out = out_flags.chain;

endmodule

// File: rtl/irq_prio_cascade_chk.sv
module irq_prio_cascade_chk #(
  parameter int unsigned LINES = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             irq_en,
  input logic [LINES-1:0] irq_req,
  input logic [IDX_W-1:0] irq_idx,
  input logic             irq_pending,
  input logic             irq_chain_out
);

  always_comb begin
    // R1: the reported line is raised and nothing above it is.
    if (irq_en && (|irq_req)) begin
      assert_highest_wins_R1: assert ((irq_req >> irq_idx) == LINES'(1))
        else $error("R1 index %0d not highest of %b", irq_idx, irq_req);
    end
    // R2: disabled block reports nothing.
    if (!irq_en) begin
      assert_disabled_quiet_R2: assert (irq_idx == '0 && !irq_pending && !irq_chain_out)
        else $error("R2 outputs active while disabled");
    end
    // R3
    assert_pending_R3: assert (irq_pending == (irq_en && (|irq_req)))
      else $error("R3 pending flag wrong");
    // R4
    assert_chain_out_R4: assert (irq_chain_out == (irq_en && !(|irq_req)))
      else $error("R4 chain output wrong");
    // R5
    if (irq_en && !(|irq_req)) begin
      assert_idle_index_R5: assert (irq_idx == '0)
        else $error("R5 idle index not zero");
    end
    // R6: any upper-half request sets the index MSB.
    if (irq_en) begin
      assert_upper_first_R6: assert (irq_idx[IDX_W-1] == (|irq_req[LINES-1:LINES/2]))
        else $error("R6 upper stage priority broken");
    end
    // R7: one-hot input gives the OR form of each index bit.
    if (irq_en && $onehot(irq_req)) begin
      for (int b = 0; b < IDX_W; b++) begin
        automatic logic orv = 1'b0;
        for (int i = 0; i < LINES; i++) begin
          if (((i >> b) % 2) == 1) orv = orv | irq_req[i];
        end
        assert_onehot_or_R7: assert (irq_idx[b] == orv)
          else $error("R7 index bit %0d wrong", b);
      end
    end
  end

endmodule

bind irq_prio_cascade irq_prio_cascade_chk #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (
  .irq_en        (irq_en),
  .irq_req       (irq_req),
  .irq_idx       (irq_idx),
  .irq_pending   (irq_pending),
  .irq_chain_out (irq_chain_out)
);

// File: tb/tb_irq_prio_cascade.sv
module tb_irq_prio_cascade;

  localparam int unsigned LINES = 8;
  localparam int unsigned IDX_W = 3;

  typedef struct {
    logic [IDX_W-1:0] idx;
    logic             pending;
    logic             chain;
    logic             en;
    logic [LINES-1:0] req;
    string            tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             irq_en;
  logic [LINES-1:0] irq_req;
  logic [IDX_W-1:0] irq_idx;
  logic             irq_pending;
  logic             irq_chain_out;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   drv_done = 1'b0;
  exp_t sb_q[$];

  always #4 clk = ~clk;  // 125 MHz

  irq_prio_cascade dut (
    .irq_en        (irq_en),
    .irq_req       (irq_req),
    .irq_idx       (irq_idx),
    .irq_pending   (irq_pending),
    .irq_chain_out (irq_chain_out)
  );

  // Reference: highest set bit, gated by the enable.
  task automatic drive(input logic en, input logic [LINES-1:0] req);
    exp_t e;
    @(negedge clk);
    irq_en  = en;
    irq_req = req;
    e.idx = '0;
    for (int i = 0; i < LINES; i++) if (en && req[i]) e.idx = IDX_W'(i);
    e.pending = en && (req != '0);
    e.chain   = en && (req == '0);
    e.en  = en;
    e.req = req;
    if (!en)                                   e.tag = "R2";
    else if (req == '0)                        e.tag = "R5";
    else if ($onehot(req))                     e.tag = "R7";
    else if ((|req[7:4]) && (|req[3:0]))       e.tag = "R6";
    else                                       e.tag = "R1";
    sb_q.push_back(e);
  endtask

  // Monitor: compare half a period after the inputs change.
  always @(posedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (irq_idx !== e.idx) begin
        n_bad++;
        $display("FAIL %s idx en=%b req=%b actual=%0d expected=%0d",
                 e.tag, e.en, e.req, irq_idx, e.idx);
      end
      n_cmp++;
      if (irq_pending !== e.pending) begin
        n_bad++;
        $display("FAIL R3 pending en=%b req=%b actual=%b expected=%b",
                 e.en, e.req, irq_pending, e.pending);
      end
      n_cmp++;
      if (irq_chain_out !== e.chain) begin
        n_bad++;
        $display("FAIL R4 chain_out en=%b req=%b actual=%b expected=%b",
                 e.en, e.req, irq_chain_out, e.chain);
      end
    end
  end

  initial begin
    rst_n   = 1'b0;
    irq_en  = 1'b0;
    irq_req = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Reset-like state: disabled and idle (R2).
    drive(1'b0, 8'h00);
    // Idle enabled (R5) and line 0 alone (R5 contrast via pending).
    drive(1'b1, 8'h00);
    drive(1'b1, 8'h01);
    // Upper stage overrides lower (R6).
    drive(1'b1, 8'h1F);
    drive(1'b1, 8'h8F);
    // Full sweep: every pattern, enable high then low (R1, R2, R7).
    for (int en_i = 1; en_i >= 0; en_i--) begin
      for (int p = 0; p < (1 << LINES); p++) begin
        drive(en_i[0], LINES'(p));
      end
    end
    wait (sb_q.size() == 0);
    @(negedge clk);
    drv_done = 1'b1;
  end

  initial begin
    fork
      wait (drv_done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule